// File: doc/BRIEF.md
# SRAM Column Supply Select Controller

This block drives the per-column supply-rail selection of an SRAM array. Each physical column gets one select bit: 1 means the high cell rail and 0 means the low cell rail. The selection depends on the requested array operation and on the column-mux address. With no access pending, every column sits on the low rail to cut leakage. A read raises every column, which hardens the accessed row against read disturb. A write keeps the addressed column of each mux group low so its cells flip easily. The other columns of each group, which share the active wordline, are raised.

The block also sequences the wordline enable around the rail change. The wordline only rises after the select pattern has been held for a programmable number of settle cycles. After the access, the wordline falls, the pattern is held for one more cycle, and then the pattern returns to all-low. A new request accepted in that release cycle moves straight to its own pattern without passing through all-low, but it still waits out the settle delay.

Top module: `col_supply_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, every bit of `col_hi_sel` is 0, `wl_en` is 0 and `seq_ready` is 1.
- R2: A read request (`req_op` = 2'b01) sets every bit of `col_hi_sel` to 1.
- R3: A write request (`req_op` = 2'b10) sets bit c of `col_hi_sel` to 0 when c mod MUX_RATIO equals `req_col`, and to 1 otherwise.
- R4: `wl_en` rises SETTLE_CYC cycles after `col_hi_sel` takes the new pattern, and `col_hi_sel` does not change while `wl_en` is 1.
- R5: `wl_en` stays high for exactly WL_CYC consecutive cycles per access.
- R6: After `wl_en` falls, the pattern is held for one cycle with `wl_en` low. It then returns to all-low unless a new request is accepted.
- R7: `seq_ready` is 1 only when the block is idle or in the release cycle. A request presented while `seq_ready` is 0 is ignored and leaves `col_hi_sel` unchanged.
- R8: A read or write request accepted in the release cycle loads its own pattern directly at the next edge, with no all-low cycle in between, and still waits SETTLE_CYC cycles before `wl_en` rises.
- R9: A request with `req_op` = 2'b00 (standby) or 2'b11 (reserved) is accepted but keeps all selects low and never raises `wl_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled when `seq_ready` is 1 |
| req_op | input | 2 | Operation: 00 standby, 01 read, 10 write, 11 treated as standby |
| req_col | input | MUX_W | Column-mux select for writes |
| col_hi_sel | output | NUM_COLS | Per-column rail select, 1 means high rail |
| wl_en | output | 1 | Wordline enable |
| seq_ready | output | 1 | Block can accept a request this cycle |

## Verification
The pattern check runs reads, writes to the first, a middle and the last mux slot, and standby and reserved codes. This tells a correct slot decode apart from an off-by-one slot, an inverted polarity, or a read that raises only part of the columns. Each access is timed edge by edge, so a wrong settle count, a wrong wordline length or a missing release cycle shows as a mismatch in a specific cycle. Directed cases cover a request raised while the block is busy, which must be dropped. They also cover a back-to-back request raised in the release cycle, which must switch directly from one pattern to the other.

// File: rtl/col_supply_pkg.sv
package col_supply_pkg;

    typedef enum logic [1:0] {
        OP_STBY = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_RSV  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SETTLE = 2'b01,
        ST_ACTIVE = 2'b10,
        ST_HOLD   = 2'b11
    } seq_st_e;

endpackage

// File: rtl/col_pattern_gen.sv
module col_pattern_gen
    import col_supply_pkg::*;
#(
    parameter int NUM_COLS  = 32,
    parameter int MUX_RATIO = 8,
    localparam int MUX_W    = (MUX_RATIO > 1) ? $clog2(MUX_RATIO) : 1
) (
    input  logic [1:0]          op,
    input  logic [MUX_W-1:0]    col,
    output logic [NUM_COLS-1:0] pattern
);

    logic is_rd;
    logic is_wr;

    assign is_rd = (op == OP_RD);
    assign is_wr = (op == OP_WR);

    // Each column knows its own slot within the mux group.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int SLOT = c % MUX_RATIO;
        assign pattern[c] = is_rd | (is_wr & (col != MUX_W'(SLOT)));
    end

endmodule

// File: rtl/col_seq_fsm.sv
module col_seq_fsm
    import col_supply_pkg::*;
#(
    parameter int NUM_COLS   = 32,
    parameter int MUX_RATIO  = 8,
    parameter int SETTLE_CYC = 1,
    parameter int WL_CYC     = 2,
    localparam int CNT_MAX   = (SETTLE_CYC > WL_CYC) ? SETTLE_CYC : WL_CYC,
    localparam int CNT_W     = (CNT_MAX > 1) ? $clog2(CNT_MAX + 1) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [NUM_COLS-1:0] req_pattern,
    output logic [NUM_COLS-1:0] sel,
    output logic                wl,
    output logic                ready
);

    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] WL_LAST     = CNT_W'(WL_CYC - 1);

    typedef struct packed {
        seq_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [NUM_COLS-1:0] sel;
        logic                wl;
        logic [1:0]          op;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;
    logic is_access;

    assign ready     = (s_q.st == ST_IDLE) || (s_q.st == ST_HOLD);
    assign accept    = ready && req_valid;
    assign is_access = (req_op == OP_RD) || (req_op == OP_WR);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE, ST_HOLD: begin
                s_d.wl  = 1'b0;
                s_d.cnt = '0;
                if (accept && is_access) begin
                    s_d.st  = ST_SETTLE;
                    s_d.sel = req_pattern;
                    s_d.op  = req_op;
                end else begin
                    s_d.st  = ST_IDLE;
                    s_d.sel = '0;
                    s_d.op  = OP_STBY;
                end
            end
            ST_SETTLE: begin
                if (s_q.cnt == SETTLE_LAST) begin
                    s_d.st  = ST_ACTIVE;
                    s_d.cnt = '0;
                    s_d.wl  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (s_q.cnt == WL_LAST) begin
                    s_d.st  = ST_HOLD;
                    s_d.cnt = '0;
                    s_d.wl  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, sel: '0, wl: 1'b0, op: OP_STBY};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel = s_q.sel;
    assign wl  = s_q.wl;

    // R1: idle means every column on the low rail
    a_r1_idle_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |-> (s_q.sel == '0 && !s_q.wl));

    // R4: the pattern is already settled when the wordline rises
    a_r4_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wl) |-> $stable(s_q.sel));

    // R4: no pattern change during the wordline pulse
    a_r4_stable_during_wl: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wl && $past(s_q.wl)) |-> $stable(s_q.sel));

    // R6: the pattern is still held in the cycle the wordline falls
    a_r6_hold_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.wl) |-> $stable(s_q.sel));

    // R7: not ready while the wordline is up
    a_r7_busy_when_wl: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wl |-> !ready);

    // R3: a write lowers exactly one column per mux group
    a_r3_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wl && s_q.op == OP_WR) |->
            ($countones(s_q.sel) == NUM_COLS - (NUM_COLS / MUX_RATIO)));

    // R2: a read raises every column
    a_r2_read_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wl && s_q.op == OP_RD) |-> (s_q.sel == '1));

endmodule

// File: rtl/col_supply_ctrl.sv
module col_supply_ctrl
    import col_supply_pkg::*;
#(
    parameter int NUM_COLS   = 32,
    parameter int MUX_RATIO  = 8,
    parameter int SETTLE_CYC = 1,
    parameter int WL_CYC     = 2,
    localparam int MUX_W     = (MUX_RATIO > 1) ? $clog2(MUX_RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [MUX_W-1:0]    req_col,
    output logic [NUM_COLS-1:0] col_hi_sel,
    output logic                wl_en,
    output logic                seq_ready
);

    logic [NUM_COLS-1:0] next_pattern;

    col_pattern_gen #(
        .NUM_COLS  (NUM_COLS),
        .MUX_RATIO (MUX_RATIO)
    ) u_pattern (
        .op      (req_op),
        .col     (req_col),
        .pattern (next_pattern)
    );

    col_seq_fsm #(
        .NUM_COLS   (NUM_COLS),
        .MUX_RATIO  (MUX_RATIO),
        .SETTLE_CYC (SETTLE_CYC),
        .WL_CYC     (WL_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_pattern (next_pattern),
        .sel         (col_hi_sel),
        .wl          (wl_en),
        .ready       (seq_ready)
    );

endmodule

// File: tb/col_supply_ctrl_bench.sv
module col_supply_ctrl_bench;

    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [2:0]    req_col = 3'd0;
    logic [NC-1:0] col_hi_sel;
    logic          wl_en;
    logic          seq_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    col_supply_ctrl u_col_supply_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_col    (req_col),
        .col_hi_sel (col_hi_sel),
        .wl_en      (wl_en),
        .seq_ready  (seq_ready)
    );

    // {op, col, expected pattern}
    localparam logic [36:0] VEC [7] = '{
        {2'b01, 3'd0, 32'hFFFF_FFFF},
        {2'b10, 3'd0, 32'hFEFE_FEFE},
        {2'b10, 3'd3, 32'hF7F7_F7F7},
        {2'b10, 3'd7, 32'h7F7F_7F7F},
        {2'b01, 3'd5, 32'hFFFF_FFFF},
        {2'b00, 3'd2, 32'h0000_0000},
        {2'b11, 3'd4, 32'h0000_0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] col);
        req_valid = 1'b1;
        req_op    = op;
        req_col   = col;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Called on the negedge after acceptance; walks settle, pulse, release.
    task automatic check_access(input logic [31:0] pat, input bit last_idle);
        chk(col_hi_sel == pat, "R2/R3 pattern", col_hi_sel, pat);
        chk(wl_en == 1'b0, "R4 settle wl low", 32'(wl_en), 32'd0);
        chk(seq_ready == 1'b0, "R7 busy in settle", 32'(seq_ready), 32'd0);
        @(negedge clk);
        chk(wl_en == 1'b1, "R4 wl after settle", 32'(wl_en), 32'd1);
        chk(col_hi_sel == pat, "R4 sel stable wl", col_hi_sel, pat);
        @(negedge clk);
        chk(wl_en == 1'b1, "R5 wl second cycle", 32'(wl_en), 32'd1);
        @(negedge clk);
        chk(wl_en == 1'b0, "R5 wl length", 32'(wl_en), 32'd0);
        chk(col_hi_sel == pat, "R6 release hold", col_hi_sel, pat);
        chk(seq_ready == 1'b1, "R7 ready release", 32'(seq_ready), 32'd1);
        if (last_idle) begin
            @(negedge clk);
            chk(col_hi_sel == '0, "R6 back to low", col_hi_sel, 32'd0);
            chk(seq_ready == 1'b1, "R1 idle ready", 32'(seq_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(col_hi_sel == '0, "R1 reset sel", col_hi_sel, 32'd0);
        chk(wl_en == 1'b0, "R1 reset wl", 32'(wl_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seq_ready == 1'b1, "R1 reset ready", 32'(seq_ready), 32'd1);

        for (int i = 0; i < 7; i++) begin
            issue(VEC[i][36:35], VEC[i][34:32]);
            if (VEC[i][36:35] == 2'b01 || VEC[i][36:35] == 2'b10) begin
                check_access(VEC[i][31:0], 1'b1);
            end else begin
                // R9 standby / reserved: nothing moves
                for (int k = 0; k < 4; k++) begin
                    chk(col_hi_sel == '0 && wl_en == 1'b0, "R9 standby",
                        {col_hi_sel[30:0], wl_en}, 32'd0);
                    @(negedge clk);
                end
            end
        end

        // R7: request while busy is dropped
        issue(2'b10, 3'd1);
        req_valid = 1'b1;
        req_op    = 2'b01;
        @(negedge clk);
        chk(col_hi_sel == 32'hFDFD_FDFD, "R7 busy ignore", col_hi_sel, 32'hFDFD_FDFD);
        req_valid = 1'b0;
        @(negedge clk);
        chk(col_hi_sel == 32'hFDFD_FDFD, "R7 busy ignore later", col_hi_sel, 32'hFDFD_FDFD);
        @(negedge clk);
        chk(wl_en == 1'b0 && seq_ready == 1'b1, "R7 release after ignore",
            {30'd0, wl_en, seq_ready}, 32'd1);
        // in release: back-to-back read
        issue(2'b01, 3'd0);
        // R8: direct switch, no all-low cycle, settle still applied
        check_access(32'hFFFF_FFFF, 1'b0);
        issue(2'b10, 3'd6);
        check_access(32'hBFBF_BFBF, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule